// File: doc/BRIEF.md
# Deflection Side Buffer

This block sits directly after the deflection arbiter of a bufferless router. Each cycle it looks at the router's output slots. For each slot it sees a valid bit, a golden (global top priority) bit and a flag that says the arbiter had to send the flit away from its productive direction. The block may take at most one of those misrouted flits out of the outputs each cycle. It stores that flit in a small FIFO and clears the valid bit of the slot it took, so the flit does not leave on the wrong link. Flits that were routed productively pass untouched, and the data lanes pass straight through to the links.

At the front of the pipeline, the block offers the oldest buffered flit to the injection stage. Whenever the injection stage reports a free slot, the offered flit is taken and popped from the FIFO. While the FIFO holds anything, a local injection request is refused, so buffered traffic always re-enters ahead of new local traffic. A capture and a reinjection may both happen in one cycle. The occupancy then stays the same.

Top module: `defl_side_buffer`

## Requirements
- R1: A slot is removed from `slot_valid_o` only if it carries a valid, misrouted, non-golden flit. Every other valid slot, golden slots included, appears unchanged on `slot_valid_o`.
- R2: When several slots qualify for capture, the one with the lowest port index is taken. At most one slot is removed per cycle.
- R3: The captured slot's bit in `slot_valid_o` is cleared combinationally in the same cycle. The data of that slot is written into the FIFO at the next rising clock edge.
- R4: When the FIFO already holds `DEPTH` flits at the start of the cycle, nothing is captured, even if a pop happens in that cycle. The misrouted flit stays valid on its output.
- R5: Reinjected flits come out in the order they were captured.
- R6: `reinj_valid_o` is high exactly when the FIFO is not empty, and `reinj_data_o` then shows the oldest flit. `reinj_take_o` equals `inj_slot_free_i` AND `reinj_valid_o`, and a take pops that flit at the next rising edge.
- R7: `loc_gnt_o` is high only when `inj_slot_free_i` and `loc_req_i` are both high and the FIFO is empty. Reinjection wins the free slot.
- R8: A capture and a take in the same cycle leave the occupancy unchanged. A capture alone raises it by one, and a take alone lowers it by one.
- R9: With the default `DEPTH` of 4, exactly four flits can be held at once.
- R10: After reset the FIFO is empty, so `reinj_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid_i | input | NP | Valid bit of each output slot from the arbiter |
| slot_gold_i | input | NP | Golden-priority bit of each slot |
| slot_defl_i | input | NP | Slot was routed away from its productive direction |
| slot_data_i | input | NP*DW | Flit payloads, port p in bits p*DW +: DW |
| slot_valid_o | output | NP | Valid bits toward the links after capture |
| inj_slot_free_i | input | 1 | Injection stage has a free slot this cycle |
| loc_req_i | input | 1 | Local injection wants the free slot |
| loc_gnt_o | output | 1 | Local injection may use the free slot |
| reinj_valid_o | output | 1 | A buffered flit is offered for reinjection |
| reinj_data_o | output | DW | Payload of the offered flit |
| reinj_take_o | output | 1 | Offered flit placed into the free slot this cycle |

## Verification
The bench builds the block with four ports, 8-bit payloads and the default depth of four. With this configuration it can sweep every combination of valid, golden and misroute flags across all four slots, with a free injection slot draining each capture. It then fills the FIFO to its exact limit and checks that a capture is refused while a drain happens in the same cycle. Finally, a long pseudo-random mix of flags and free-slot patterns drives the occupancy up and down, and the bench compares it against a queue model.

// File: rtl/defl_sbuf_pkg.sv
package defl_sbuf_pkg;
   // width of a counter that must hold values 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
   // width of an index into n entries (at least one bit)
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 3) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/defl_sbuf_pick.sv
module defl_sbuf_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]                            req,
   output logic [N-1:0]                            gnt,
   output logic [defl_sbuf_pkg::idx_w(N)-1:0]      idx,
   output logic                                    any
);
   localparam int unsigned IW = defl_sbuf_pkg::idx_w(N);

   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < int'(N); i++) begin
         if (req[i] && !any) begin
            any    = 1'b1;
            gnt[i] = 1'b1;
            idx    = IW'(i);
         end
      end
   end
endmodule

// File: rtl/defl_sbuf_fifo.sv
module defl_sbuf_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    push,
   input  logic                                    pop,
   input  logic [DW-1:0]                           wdata,
   output logic [DW-1:0]                           rdata,
   output logic [defl_sbuf_pkg::cnt_w(DEPTH)-1:0]  lvl,
   output logic                                    full,
   output logic                                    empty
);
   localparam int unsigned PW = defl_sbuf_pkg::idx_w(DEPTH);
   localparam int unsigned CW = defl_sbuf_pkg::cnt_w(DEPTH);
   localparam bit          POW2 = (DEPTH == (1 << PW));

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign full  = (lvl == CW'(DEPTH));
   assign empty = (lvl == '0);
   assign rdata = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         lvl <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         lvl <= lvl + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end
endmodule

// File: rtl/defl_side_buffer.sv
module defl_side_buffer #(
   parameter int unsigned NP    = 4,
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NP-1:0]    slot_valid_i,
   input  logic [NP-1:0]    slot_gold_i,
   input  logic [NP-1:0]    slot_defl_i,
   input  logic [NP*DW-1:0] slot_data_i,
   output logic [NP-1:0]    slot_valid_o,
   input  logic             inj_slot_free_i,
   input  logic             loc_req_i,
   output logic             loc_gnt_o,
   output logic             reinj_valid_o,
   output logic [DW-1:0]    reinj_data_o,
   output logic             reinj_take_o
);
   localparam int unsigned IW = defl_sbuf_pkg::idx_w(NP);
   localparam int unsigned CW = defl_sbuf_pkg::cnt_w(DEPTH);

   generate
      if (NP < 2)    begin : g_bad_np    $error("NP must be at least 2");    end
      if (DW < 1)    begin : g_bad_dw    $error("DW must be at least 1");    end
      if (DEPTH < 1) begin : g_bad_depth $error("DEPTH must be at least 1"); end
   endgenerate

   logic [NP-1:0] cand, cap_oh;
   logic [IW-1:0] cap_idx;
   logic          cand_any, cap_w, full_w, empty_w;
   logic [CW-1:0] lvl;
   logic [DW-1:0] cap_data;

   assign cand = slot_valid_i & slot_defl_i & ~slot_gold_i;

   defl_sbuf_pick #(.N(NP)) u_pick (
      .req (cand),
      .gnt (cap_oh),
      .idx (cap_idx),
      .any (cand_any)
   );

   assign cap_w        = cand_any & ~full_w;
   assign cap_data     = slot_data_i[cap_idx*DW +: DW];
   assign slot_valid_o = slot_valid_i & ~(cap_w ? cap_oh : '0);

   assign reinj_valid_o = ~empty_w;
   assign reinj_take_o  = inj_slot_free_i & ~empty_w;
   assign loc_gnt_o     = inj_slot_free_i & loc_req_i & empty_w;

   defl_sbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (cap_w),
      .pop   (reinj_take_o),
      .wdata (cap_data),
      .rdata (reinj_data_o),
      .lvl   (lvl),
      .full  (full_w),
      .empty (empty_w)
   );
endmodule

// File: rtl/defl_side_buffer_chk.sv
module defl_side_buffer_chk #(
   parameter int unsigned NP    = 4,
   parameter int unsigned DEPTH = 4
) (
   input logic                                   clk,
   input logic                                   rst_n,
   input logic [NP-1:0]                          slot_valid_i,
   input logic [NP-1:0]                          slot_gold_i,
   input logic [NP-1:0]                          slot_defl_i,
   input logic [NP-1:0]                          slot_valid_o,
   input logic                                   inj_slot_free_i,
   input logic                                   loc_req_i,
   input logic                                   loc_gnt_o,
   input logic                                   reinj_valid_o,
   input logic                                   reinj_take_o,
   input logic [defl_sbuf_pkg::cnt_w(DEPTH)-1:0] lvl
);
   logic [NP-1:0] dropped;
   assign dropped = slot_valid_i & ~slot_valid_o;

   p_drop_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dropped & ~(slot_defl_i & ~slot_gold_i)) == '0);

   p_no_new_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_o & ~slot_valid_i) == '0);

   p_single_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dropped));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= (defl_sbuf_pkg::cnt_w(DEPTH))'(DEPTH));

   p_full_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == (defl_sbuf_pkg::cnt_w(DEPTH))'(DEPTH)) |-> (dropped == '0));

   p_take_needs_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reinj_take_o |-> (reinj_valid_o && inj_slot_free_i));

   p_local_yields_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reinj_valid_o |-> !loc_gnt_o);

   p_level_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (lvl == $past(lvl) + (defl_sbuf_pkg::cnt_w(DEPTH))'($countones($past(dropped)))
                        - (defl_sbuf_pkg::cnt_w(DEPTH))'($past(reinj_take_o))));

   p_empty_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == '0) |-> !reinj_valid_o);
endmodule

bind defl_side_buffer defl_side_buffer_chk #(.NP(NP), .DEPTH(DEPTH)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .slot_valid_i    (slot_valid_i),
   .slot_gold_i     (slot_gold_i),
   .slot_defl_i     (slot_defl_i),
   .slot_valid_o    (slot_valid_o),
   .inj_slot_free_i (inj_slot_free_i),
   .loc_req_i       (loc_req_i),
   .loc_gnt_o       (loc_gnt_o),
   .reinj_valid_o   (reinj_valid_o),
   .reinj_take_o    (reinj_take_o),
   .lvl             (lvl)
);

// File: tb/tb_defl_side_buffer.sv
`timescale 1ns/1ps
module tb_defl_side_buffer;
   localparam int NP = 4, DW = 8, DEPTH = 4;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic [NP-1:0]    v = '0, g = '0, d = '0, vo;
   logic [NP*DW-1:0] dat = '0;
   logic             free = 1'b0, lreq = 1'b0, lgnt, rv, take;
   logic [DW-1:0]    rdat;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [DW-1:0] q[$];

   always #10 clk = ~clk;

   defl_side_buffer #(.NP(NP), .DW(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .slot_valid_i(v), .slot_gold_i(g),
      .slot_defl_i(d), .slot_data_i(dat), .slot_valid_o(vo),
      .inj_slot_free_i(free), .loc_req_i(lreq), .loc_gnt_o(lgnt),
      .reinj_valid_o(rv), .reinj_data_o(rdat), .reinj_take_o(take));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // drive one cycle, check outputs mid-cycle, update model
   task automatic step(input logic [3:0] vi, input logic [3:0] gi, input logic [3:0] di,
                       input logic fi, input logic li, input logic [31:0] di_dat);
      logic [3:0] cand, oh;
      bit cap, full, nonempty;
      @(negedge clk);
      v = vi; g = gi; d = di; free = fi; lreq = li; dat = di_dat;
      #2;
      cand = vi & di & ~gi;
      oh   = cand & (~cand + 4'd1);
      full = (q.size() == DEPTH);
      nonempty = (q.size() != 0);
      cap  = (cand != 0) && !full;
      if (full && cand != 0) chk("R4 full keeps slot", vo, vi);
      else chk("R1 R2 R3 slot valid out", vo, vi & ~(cap ? oh : 4'd0));
      chk("R6 R10 offer", rv, nonempty);
      if (nonempty) chk("R5 order", rdat, q[0]);
      chk("R6 take", take, fi && nonempty);
      chk("R7 local grant", lgnt, fi && li && !nonempty);
      if (fi && nonempty) void'(q.pop_front());
      if (cap) begin
         int p = 0;
         for (int i = 3; i >= 0; i--) if (oh[i]) p = i;
         q.push_back(di_dat[p*8 +: 8]);
      end
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(posedge clk);
      @(negedge clk);
      free = 1'b1; lreq = 1'b1; v = 4'hF;
      #2;
      chk("R10 reset offer", rv, 0);
      chk("R10 reset local grant", lgnt, 1);
      chk("R10 reset slots", vo, 4'hF);
      rst_n = 1'b1;

      // R1 R2 R3 R8: every flag combination, drained each cycle
      for (int k = 0; k < 4096; k++) begin
         logic [31:0] dd;
         for (int p = 0; p < 4; p++) dd[p*8 +: 8] = 8'((k * 4 + p) & 255);
         step(k[3:0], k[7:4], k[11:8], 1'b1, k[0] ^ k[5], dd);
      end
      repeat (3) step(4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 32'h0);

      // R9 R4: fill to the limit, then refuse
      for (int n = 0; n < 4; n++) step(4'hF, 4'h1, 4'h7, 1'b0, 1'b1, 32'hA0B0C0D0 + 32'(n));
      chk("R9 depth four", q.size(), 4);
      step(4'hF, 4'h0, 4'h8, 1'b0, 1'b1, 32'h11223344);
      step(4'hF, 4'h0, 4'h2, 1'b1, 1'b1, 32'h55667788); // R4 full, pop same cycle
      step(4'hF, 4'h0, 4'h4, 1'b1, 1'b1, 32'h99AABBCC); // R8 capture and take
      repeat (6) step(4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 32'h0); // R5 drain order

      // R8: pseudo-random occupancy walk
      lf = 16'hACE1;
      for (int c = 0; c < 3000; c++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[3:0] | lf[11:8], lf[7:4] & lf[15:12], lf[11:8] | lf[2:0],
              lf[5] & lf[9], lf[6], {lf, lf ^ 16'h5A5A});
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule